// File: doc/BRIEF.md
# Interlocked Request/Acknowledge Bus Controller Pair

This block joins an initiator-side controller and a responder-side controller over a strobed bus that has no shared clock. The bus carries an address, a direction line, data, a request strobe from the initiator and an acknowledge strobe from the responder. Each controller is a synchronous state machine in its own clock domain, and each passes the strobe it receives through a two-flop synchronizer before acting on it. This lets the two halves run from unrelated clocks.

On the initiator side, a command enters through a valid/ready port. The controller places the address and direction on the bus, and the write data as well for a write. It then waits a fixed number of its own cycles so the responder can decode the address, and only then raises request. It drops request once it has seen acknowledge, capturing read data in the same cycle, and waits for acknowledge to fall before it reports the result on a valid/ready response port. A command is taken only while `cmd_valid` and `cmd_ready` are both high at a clock edge, and `cmd_ready` stays low from that edge until the response has been taken. A response holds `rsp_valid` and its payload steady until `rsp_ready` is sampled high, so the consumer may stall it for any number of cycles.

The responder owns a small register bank at one aligned address window. On a write it stores the data and then acknowledges. On a read it first drives the bank entry onto the data lines and then acknowledges. It releases acknowledge, and stops driving, only after it has seen request low. An address outside the window is never acknowledged. In that case the initiator gives up after a set number of request cycles, withdraws request, and reports a timeout.

Top module: `hs4_bus_pair`

## Requirements
- R1: While either reset is held, and at the first sample after it is released, `cmd_ready`=1, `rsp_valid`=0, `bus_req_o`=0 and `bus_ack_o`=0.
- R2: Request rises exactly SETTLE_CYC initiator cycles after the edge that accepts a command. The address and direction on the bus equal the accepted command from that edge until request falls.
- R3: Request falls only while acknowledge is high, except after a timeout. Acknowledge rises only while request is high.
- R4: Acknowledge falls only while request is low. When a response is offered, both strobes are low, and no new command is accepted before that.
- R5: A write (`cmd_write`=1) to an address whose upper AW-LAW bits equal those of BASE stores `cmd_wdata` in entry `addr[LAW-1:0]`. Every entry reads as zero after reset.
- R6: A read (`cmd_write`=0) to a matching address returns the last value written to that entry in `rsp_rdata`. Data is driven by the responder only during reads and by the initiator only during writes, never by both at once.
- R7: An access to a non-matching address never raises acknowledge. After TIMEOUT_CYC request cycles, request is withdrawn and the response carries `rsp_timeout`=1. Responses to matching accesses carry `rsp_timeout`=0.
- R8: `rsp_valid`, `rsp_rdata` and `rsp_timeout` hold steady until `rsp_ready` is sampled high. `cmd_ready` is low while a response is pending.
- R9: Each strobe acts on the far side only after two receiving-domain flops. Acknowledge rises no earlier than two responder cycles after request was first sampled high, and at least two initiator cycles after request rose as seen by the initiator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_m | input | 1 | Initiator clock |
| rst_m_n | input | 1 | Initiator reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | AW | Command address |
| cmd_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | DW | Read data (zero for writes and timeouts) |
| rsp_timeout | output | 1 | Access was not acknowledged |
| clk_s | input | 1 | Responder clock |
| rst_s_n | input | 1 | Responder reset, active low |
| bus_req_o | output | 1 | Request strobe as seen on the bus |
| bus_ack_o | output | 1 | Acknowledge strobe as seen on the bus |

## Verification
A new command can be offered in the same cycle in which the previous response is taken. The command must neither be lost nor overtake the response. The bench provokes this by raising `cmd_valid` with a read of the just-written entry while the write response is still stalled. It first checks that `cmd_ready` stays low. It then releases `rsp_ready` and confirms that the write response arrives first, followed by a read that returns the new value after a normal settle delay. Stalled responses with random lengths and random matching and non-matching traffic exercise the same boundary repeatedly.

// File: rtl/hs4_pkg.sv
package hs4_pkg;
  typedef enum logic [2:0] {
    M_IDLE, M_SETTLE, M_REQ, M_WAITLO, M_RESP
  } mst_state_e;

  typedef enum logic [1:0] {
    S_IDLE, S_PREP, S_HOLD
  } slv_state_e;
endpackage

// File: rtl/hs4_sync2.sv
module hs4_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      q      <= 1'b0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/hs4_initiator.sv
module hs4_initiator
  import hs4_pkg::*;
#(
  parameter int AW          = 8,
  parameter int DW          = 16,
  parameter int SETTLE_CYC  = 3,
  parameter int TIMEOUT_CYC = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_timeout,
  output logic [AW-1:0] bus_addr,
  output logic          bus_write,
  output logic          bus_req,
  input  logic          bus_ack,
  output logic [DW-1:0] bus_mdata,
  output logic          bus_mdrive,
  input  logic [DW-1:0] bus_rdata
);
  localparam int MAXC = (SETTLE_CYC > TIMEOUT_CYC) ? SETTLE_CYC : TIMEOUT_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SET_LAST = CW'(SETTLE_CYC - 1);
  localparam logic [CW-1:0] TMO_LAST = CW'(TIMEOUT_CYC - 1);

  mst_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] addr_q;
  logic          wr_q, req_q, tmo_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          ack_s;

  hs4_sync2 u_ack_sync (.clk(clk), .rst_n(rst_n), .d(bus_ack), .q(ack_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= M_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      req_q   <= 1'b0;
      tmo_q   <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      case (state_q)
        M_IDLE: if (cmd_valid) begin
          addr_q  <= cmd_addr;
          wr_q    <= cmd_write;
          wdata_q <= cmd_wdata;
          rdata_q <= '0;
          tmo_q   <= 1'b0;
          cnt_q   <= '0;
          state_q <= M_SETTLE;
        end
        M_SETTLE: if (cnt_q == SET_LAST) begin
          cnt_q   <= '0;
          req_q   <= 1'b1;
          state_q <= M_REQ;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        M_REQ: if (ack_s) begin
          req_q <= 1'b0;
          if (!wr_q) rdata_q <= bus_rdata;
          state_q <= M_WAITLO;
        end else if (cnt_q == TMO_LAST) begin
          req_q   <= 1'b0;
          tmo_q   <= 1'b1;
          state_q <= M_WAITLO;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        M_WAITLO: if (!ack_s) state_q <= M_RESP;
        M_RESP:   if (rsp_ready) state_q <= M_IDLE;
        default:  state_q <= M_IDLE;
      endcase
    end
  end

  assign cmd_ready   = (state_q == M_IDLE);
  assign rsp_valid   = (state_q == M_RESP);
  assign rsp_rdata   = rdata_q;
  assign rsp_timeout = tmo_q;
  assign bus_addr    = addr_q;
  assign bus_write   = wr_q;
  assign bus_req     = req_q;
  assign bus_mdata   = wdata_q;
  assign bus_mdrive  = wr_q && (state_q != M_IDLE);
endmodule

// File: rtl/hs4_responder.sv
module hs4_responder
  import hs4_pkg::*;
#(
  parameter int            AW   = 8,
  parameter int            DW   = 16,
  parameter int            LAW  = 2,
  parameter logic [AW-1:0] BASE = 8'hA0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_req,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_write,
  input  logic [DW-1:0] bus_mdata,
  output logic          bus_ack,
  output logic [DW-1:0] bus_sdata,
  output logic          bus_sdrive
);
  localparam int DEPTH = 1 << LAW;

  slv_state_e    state_q;
  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] sdata_q;
  logic          ack_q, drv_q, req_s, hit;
  logic [LAW-1:0] idx;

  hs4_sync2 u_req_sync (.clk(clk), .rst_n(rst_n), .d(bus_req), .q(req_s));

  assign hit = (bus_addr[AW-1:LAW] == BASE[AW-1:LAW]);
  assign idx = bus_addr[LAW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ack_q   <= 1'b0;
      drv_q   <= 1'b0;
      sdata_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (req_s && hit) begin
          if (bus_write) begin
            mem_q[idx] <= bus_mdata;
            ack_q      <= 1'b1;
            state_q    <= S_HOLD;
          end else begin
            sdata_q <= mem_q[idx];
            drv_q   <= 1'b1;
            state_q <= S_PREP;
          end
        end
        S_PREP: begin
          ack_q   <= 1'b1;
          state_q <= S_HOLD;
        end
        S_HOLD: if (!req_s) begin
          ack_q   <= 1'b0;
          drv_q   <= 1'b0;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign bus_ack    = ack_q;
  assign bus_sdata  = sdata_q;
  assign bus_sdrive = drv_q;
endmodule

// File: rtl/hs4_bus_pair.sv
module hs4_bus_pair #(
  parameter int            AW          = 8,
  parameter int            DW          = 16,
  parameter int            LAW         = 2,
  parameter logic [AW-1:0] BASE        = 8'hA0,
  parameter int            SETTLE_CYC  = 3,
  parameter int            TIMEOUT_CYC = 20
) (
  input  logic          clk_m,
  input  logic          rst_m_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_timeout,
  input  logic          clk_s,
  input  logic          rst_s_n,
  output logic          bus_req_o,
  output logic          bus_ack_o
);
  logic [AW-1:0] b_addr;
  logic          b_write, b_req, b_ack, m_drv, s_drv;
  logic [DW-1:0] m_data, s_data, b_data;

  // Data lines: whichever side owns them for this direction drives them.
  assign b_data = s_drv ? s_data : (m_drv ? m_data : '0);

  hs4_initiator #(.AW(AW), .DW(DW), .SETTLE_CYC(SETTLE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) u_init (
    .clk(clk_m), .rst_n(rst_m_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_timeout(rsp_timeout),
    .bus_addr(b_addr), .bus_write(b_write), .bus_req(b_req), .bus_ack(b_ack),
    .bus_mdata(m_data), .bus_mdrive(m_drv), .bus_rdata(b_data)
  );

  hs4_responder #(.AW(AW), .DW(DW), .LAW(LAW), .BASE(BASE)) u_resp (
    .clk(clk_s), .rst_n(rst_s_n),
    .bus_req(b_req), .bus_addr(b_addr), .bus_write(b_write), .bus_mdata(b_data),
    .bus_ack(b_ack), .bus_sdata(s_data), .bus_sdrive(s_drv)
  );

  assign bus_req_o = b_req;
  assign bus_ack_o = b_ack;
endmodule

// File: rtl/hs4_bus_checker.sv
module hs4_bus_checker #(
  parameter int            AW   = 8,
  parameter int            DW   = 16,
  parameter int            LAW  = 2,
  parameter logic [AW-1:0] BASE = 8'hA0
) (
  input logic          clk_m,
  input logic          rst_m_n,
  input logic          clk_s,
  input logic          rst_s_n,
  input logic          b_req,
  input logic          b_ack,
  input logic [AW-1:0] b_addr,
  input logic          b_write,
  input logic          m_drv,
  input logic          s_drv,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_rdata,
  input logic          rsp_timeout
);
  logic [1:0] reqcnt_q;
  always_ff @(posedge clk_s or negedge rst_s_n) begin
    if (!rst_s_n)                reqcnt_q <= '0;
    else if (!b_req)             reqcnt_q <= '0;
    else if (reqcnt_q != 2'd3)   reqcnt_q <= reqcnt_q + 1'b1;
  end

  // R2
  a_r2_addr_held: assert property (@(posedge clk_m) disable iff (!rst_m_n)
    b_req |-> ($stable(b_addr) && $stable(b_write)));
  // R3
  a_r3_ack_needs_req: assert property (@(posedge clk_s) disable iff (!rst_s_n)
    $rose(b_ack) |-> b_req);
  a_r3_req_drop_after_ack: assert property (@(posedge clk_m) disable iff (!rst_m_n)
    $fell(b_req) |-> (b_ack || rsp_timeout));
  // R4
  a_r4_ack_drop_after_req: assert property (@(posedge clk_s) disable iff (!rst_s_n)
    $fell(b_ack) |-> !b_req);
  // R6
  a_r6_single_driver: assert property (@(posedge clk_m) disable iff (!rst_m_n)
    !(m_drv && s_drv));
  a_r6_resp_drives_reads: assert property (@(posedge clk_s) disable iff (!rst_s_n)
    s_drv |-> !b_write);
  // R7
  a_r7_no_ack_on_miss: assert property (@(posedge clk_s) disable iff (!rst_s_n)
    b_ack |-> (b_addr[AW-1:LAW] == BASE[AW-1:LAW]));
  // R8
  a_r8_rsp_hold: assert property (@(posedge clk_m) disable iff (!rst_m_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_timeout)));
  // R9
  a_r9_sync_latency: assert property (@(posedge clk_s) disable iff (!rst_s_n)
    $rose(b_ack) |-> (reqcnt_q >= 2'd2));
endmodule

bind hs4_bus_pair hs4_bus_checker #(.AW(AW), .DW(DW), .LAW(LAW), .BASE(BASE)) u_chk (
  .clk_m(clk_m), .rst_m_n(rst_m_n), .clk_s(clk_s), .rst_s_n(rst_s_n),
  .b_req(b_req), .b_ack(b_ack), .b_addr(b_addr), .b_write(b_write),
  .m_drv(m_drv), .s_drv(s_drv),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .rsp_timeout(rsp_timeout)
);

// File: tb/hs4_bus_pair_tb_top.sv
module hs4_bus_pair_tb_top;
  localparam int            CLK_PERIOD = 10;
  localparam int            SCLK_HALF  = 7;
  localparam int            AW = 8, DW = 16, LAW = 2;
  localparam logic [AW-1:0] BASE = 8'hA0;
  localparam int            SETTLE = 3, TMO = 20;

  logic clk_m = 0, clk_s = 0, rst_m_n = 0, rst_s_n = 0;
  logic cmd_valid = 0, cmd_write = 0, rsp_ready = 0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic cmd_ready, rsp_valid, rsp_timeout, bus_req_o, bus_ack_o;
  logic [DW-1:0] rsp_rdata;

  always #(CLK_PERIOD/2) clk_m = ~clk_m;
  always #(SCLK_HALF)    clk_s = ~clk_s;

  hs4_bus_pair #(.AW(AW), .DW(DW), .LAW(LAW), .BASE(BASE),
                 .SETTLE_CYC(SETTLE), .TIMEOUT_CYC(TMO)) dut_i (
    .clk_m(clk_m), .rst_m_n(rst_m_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_timeout(rsp_timeout), .clk_s(clk_s), .rst_s_n(rst_s_n),
    .bus_req_o(bus_req_o), .bus_ack_o(bus_ack_o)
  );

  int nchk = 0, nbad = 0;
  logic [DW-1:0] model [1<<LAW];
  int  ack_rises = 0, order_bad = 0;
  bit  cur_miss = 0;
  bit  done = 0;

  function automatic bit is_hit(logic [AW-1:0] a);
    return a[AW-1:LAW] == BASE[AW-1:LAW];
  endfunction

  task automatic check(bit ok, string rq, string what, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // strobe ordering monitor, sampled away from the initiator edge (R3, R4)
  logic p_req = 0, p_ack = 0;
  always @(negedge clk_m) begin
    if (rst_m_n && rst_s_n) begin
      if (!p_req && bus_req_o && (bus_ack_o || p_ack)) order_bad++;
      if (!p_ack && bus_ack_o) begin ack_rises++; if (!bus_req_o) order_bad++; end
      if (p_req && !bus_req_o && !bus_ack_o && !cur_miss) order_bad++;
      if (p_ack && !bus_ack_o && bus_req_o) order_bad++;
    end
    p_req <= bus_req_o;
    p_ack <= bus_ack_o;
  end

  task automatic issue_cmd(bit w, logic [AW-1:0] a, logic [DW-1:0] d);
    int n;
    cmd_write = w; cmd_addr = a; cmd_wdata = d; cmd_valid = 1;
    n = 0;
    while (!cmd_ready && n < 1000) begin @(negedge clk_m); n++; end
    @(posedge clk_m);
    @(negedge clk_m);
    cmd_valid = 0;
    check(cmd_ready == 0, "R8", "cmd_ready after accept", cmd_ready, 0);
    n = 1;
    while (!bus_req_o && n < 200) begin @(negedge clk_m); n++; end
    check(n - 1 == SETTLE, "R2", "settle delay", n - 1, SETTLE);
    check(dut_i.b_addr == a, "R2", "bus address", dut_i.b_addr, a);
    if (is_hit(a)) begin
      n = 0;
      while (!bus_ack_o && n < 200) begin @(negedge clk_m); n++; end
      check(n >= 2, "R9", "req-to-ack cycles", n, 2);
    end
  endtask

  task automatic get_rsp(int dly, output logic [DW-1:0] rd, output bit tmo);
    int n = 0;
    while (!rsp_valid && n < 1000) begin @(negedge clk_m); n++; end
    rd = rsp_rdata; tmo = rsp_timeout;
    check(bus_req_o == 0 && bus_ack_o == 0, "R4", "strobes at response", {bus_req_o, bus_ack_o}, 0);
    check(cmd_ready == 0, "R4", "no accept before ack low", cmd_ready, 0);
    for (int i = 0; i < dly; i++) begin
      @(negedge clk_m);
      check(rsp_valid && rsp_rdata == rd && rsp_timeout == tmo, "R8", "stalled response",
            {rsp_valid, rsp_rdata}, {1'b1, rd});
    end
    rsp_ready = 1;
    @(negedge clk_m);
    rsp_ready = 0;
  endtask

  task automatic run_txn(bit w, logic [AW-1:0] a, logic [DW-1:0] d, int dly);
    logic [DW-1:0] rd; bit tmo; int ar;
    bit hit = is_hit(a);
    cur_miss = !hit;
    ar = ack_rises;
    issue_cmd(w, a, d);
    get_rsp(dly, rd, tmo);
    if (!hit) begin
      check(tmo == 1, "R7", "timeout flag on miss", tmo, 1);
      check(ack_rises == ar, "R7", "ack rises on miss", ack_rises - ar, 0);
    end else begin
      check(tmo == 0, "R7", "timeout flag on hit", tmo, 0);
      if (w) model[a[LAW-1:0]] = d;
      else check(rd == model[a[LAW-1:0]], "R6", "read data", rd, model[a[LAW-1:0]]);
    end
    cur_miss = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk_m);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog run did not complete actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rd; bit tmo;
    void'($urandom(32'd4242));
    for (int i = 0; i < (1<<LAW); i++) model[i] = '0;
    repeat (3) @(negedge clk_m);
    check(cmd_ready == 1 && rsp_valid == 0 && bus_req_o == 0 && bus_ack_o == 0,
          "R1", "outputs in reset", {cmd_ready, rsp_valid, bus_req_o, bus_ack_o}, 4'b1000);
    rst_m_n = 1; rst_s_n = 1;
    @(negedge clk_m);
    check(cmd_ready == 1 && rsp_valid == 0 && bus_req_o == 0 && bus_ack_o == 0,
          "R1", "outputs after reset", {cmd_ready, rsp_valid, bus_req_o, bus_ack_o}, 4'b1000);

    // R5: entries start at zero
    run_txn(0, BASE | 8'd2, '0, 0);
    // R5/R6 directed write then read on every entry
    for (int i = 0; i < (1<<LAW); i++) run_txn(1, BASE | AW'(i), 16'h1111 * DW'(i + 3), 0);
    for (int i = 0; i < (1<<LAW); i++) run_txn(0, BASE | AW'(i), '0, 1);
    // R7 misses, read and write
    run_txn(0, 8'h10, '0, 0);
    run_txn(1, 8'hA4, 16'hDEAD, 2);
    check(model[0] == 16'h3333, "R5", "miss left entries alone", model[0], 16'h3333);
    run_txn(0, BASE, '0, 0);

    // R8 collision: next command offered while the write response is stalled
    issue_cmd(1, BASE | 8'd1, 16'hBEEF);
    while (!rsp_valid) @(negedge clk_m);
    cmd_write = 0; cmd_addr = BASE | 8'd1; cmd_valid = 1;
    repeat (3) begin
      @(negedge clk_m);
      check(cmd_ready == 0 && rsp_valid == 1, "R8", "command held off", cmd_ready, 0);
    end
    check(rsp_timeout == 0, "R8", "write response first", rsp_timeout, 0);
    model[1] = 16'hBEEF;
    rsp_ready = 1; @(negedge clk_m); rsp_ready = 0;
    issue_cmd(0, BASE | 8'd1, '0);
    get_rsp(0, rd, tmo);
    check(rd == 16'hBEEF && tmo == 0, "R8", "queued read after collision", rd, 16'hBEEF);

    // random traffic
    for (int k = 0; k < 60; k++) begin
      logic [AW-1:0] a;
      if ($urandom_range(0, 3) != 0) a = BASE | AW'($urandom_range(0, (1<<LAW) - 1));
      else begin
        a = AW'($urandom);
        if (is_hit(a)) a[AW-1] = ~a[AW-1];
      end
      run_txn($urandom_range(0, 1) == 1, a, DW'($urandom), $urandom_range(0, 3));
    end

    check(order_bad == 0, "R3", "strobe ordering violations", order_bad, 0);
    check(order_bad == 0, "R4", "ack release ordering", order_bad, 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule